// File: doc/BRIEF.md
# CAN FD payload length packer

This block sits in front of a CAN FD transmitter. Software or an upstream engine hands it a requested payload size (any value, with 0 to 64 meaningful) and then streams the payload bytes. The block rounds the size up to the nearest length a CAN FD frame can carry, works out the 4-bit length code, and emits the payload followed by fill bytes until the chosen length is reached.

Alongside the byte stream it presents a per-frame descriptor: the length code, a select for the CRC width the frame needs, and the four control-field flags (the dominant bit that takes the place of the remote-request bit, the FD-format flag, the bit-rate-switch flag and the error-state flag). The fill byte, bit-rate-switch request and error-state flag are captured when the size is accepted, so they may change freely while the frame is streaming. A size above 64 is clamped to 64 and latches an error flag that only reset clears.

Top module: `canfd_len_pack`

## Requirements
- R1: For a clamped size of 0 to 8 bytes, `desc_dlc` equals that size and exactly that many bytes are emitted.
- R2: Sizes of 9 to 64 are rounded up to the smallest of 12, 16, 20, 24, 32, 48, 64 that is not below them, with `desc_dlc` 9, 10, 11, 12, 13, 14, 15 respectively (e.g. 10 bytes go out as 12 with code 9).
- R3: The output carries the accepted payload bytes first, in arrival order, then fill bytes equal to `fill_in` as sampled when the size was accepted, until the rounded length is reached; a payload byte is only taken from the input in the cycle it is taken at the output.
- R4: `out_last` is 1 on the final output byte of a frame, whether payload or fill, and 0 on every other byte.
- R5: `desc_crc21` is 0 (17-bit CRC) when the rounded length is 16 or fewer bytes and 1 (21-bit CRC) when it is 20 or more.
- R6: While the descriptor is valid, `desc_rrs` is 0 and `desc_fdf` is 1.
- R7: `desc_brs` and `desc_esi` equal `brs_in` and `esi_in` as sampled when the size was accepted (1 = recessive: faster data phase, sender in error state).
- R8: A requested size above 64 is treated as 64, no more than 64 payload bytes are taken from the input, and `len_err` rises to 1 and stays 1 until reset.
- R9: `desc_valid` is 1 from the first output byte until the last byte is accepted, with all descriptor fields stable; for a zero-length frame it is 1 for exactly one cycle and no byte is emitted.
- R10: After reset `len_ready` is 1 and `out_valid`, `desc_valid`, `in_ready` and `len_err` are 0; a new size is accepted only while no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_valid | input | 1 | Requested size is present |
| len_ready | output | 1 | Block can take a new size |
| len_in | input | LEN_W | Requested payload size in bytes |
| fill_in | input | DW | Fill byte for padding |
| brs_in | input | 1 | Bit-rate-switch request (1 = faster data phase) |
| esi_in | input | 1 | Error-state flag (1 = sender in error state) |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Payload byte taken this cycle |
| in_data | input | DW | Payload byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | DW | Output byte |
| out_last | output | 1 | Final byte of the frame |
| desc_valid | output | 1 | Descriptor valid for the frame in progress |
| desc_dlc | output | 4 | Length code |
| desc_crc21 | output | 1 | 1 = 21-bit CRC, 0 = 17-bit CRC |
| desc_rrs | output | 1 | Bit in place of remote request, always 0 |
| desc_fdf | output | 1 | FD-format flag, always 1 |
| desc_brs | output | 1 | Captured bit-rate-switch flag |
| desc_esi | output | 1 | Captured error-state flag |
| len_err | output | 1 | Sticky: a size above 64 was requested |

## Verification
The assertions take for granted that the upstream side supplies the payload bytes of one frame before the next size is offered, and that downstream consumes bytes only through `out_ready`; they do not depend on `in_valid` being held. The bench keeps within this by driving each frame's size, then exactly the clamped number of payload bytes, and only offering the next size after the last output byte, with one stall cycle on alternate frames to exercise backpressure on both streams.

// File: rtl/canfd_len_pack.sv
module canfd_len_pack #(
  parameter int LEN_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_valid,
  output logic             len_ready,
  input  logic [LEN_W-1:0] len_in,
  input  logic [DW-1:0]    fill_in,
  input  logic             brs_in,
  input  logic             esi_in,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic             desc_valid,
  output logic [3:0]       desc_dlc,
  output logic             desc_crc21,
  output logic             desc_rrs,
  output logic             desc_fdf,
  output logic             desc_brs,
  output logic             desc_esi,
  output logic             len_err
);
  localparam int MAXB = 64;
  localparam int CW   = $clog2(MAXB + 1);

  function automatic logic [3:0] code_of(input logic [CW-1:0] n);
    if (n <= CW'(8))       return n[3:0];
    else if (n <= CW'(12)) return 4'd9;
    else if (n <= CW'(16)) return 4'd10;
    else if (n <= CW'(20)) return 4'd11;
    else if (n <= CW'(24)) return 4'd12;
    else if (n <= CW'(32)) return 4'd13;
    else if (n <= CW'(48)) return 4'd14;
    else                   return 4'd15;
  endfunction

  function automatic logic [CW-1:0] bytes_of(input logic [3:0] c);
    case (c)
      4'd9:    return CW'(12);
      4'd10:   return CW'(16);
      4'd11:   return CW'(20);
      4'd12:   return CW'(24);
      4'd13:   return CW'(32);
      4'd14:   return CW'(48);
      4'd15:   return CW'(64);
      default: return CW'(c);
    endcase
  endfunction

  logic          busy;
  logic [CW-1:0] plen, total, cnt;
  logic [3:0]    code_q;
  logic [DW-1:0] fill_q;
  logic          brs_q, esi_q, err_q;

  wire           over     = len_in > LEN_W'(MAXB);
  wire [CW-1:0]  req      = over ? CW'(MAXB) : len_in[CW-1:0];
  wire [3:0]     req_code = code_of(req);
  wire           len_fire = len_valid && !busy;
  wire           in_pay   = cnt < plen;
  wire           out_fire = out_valid && out_ready;

  assign len_ready  = !busy;
  assign out_valid  = busy && (in_pay ? in_valid : (total != '0));
  assign in_ready   = busy && in_pay && out_ready;
  assign out_data   = in_pay ? in_data : fill_q;
  assign out_last   = busy && (cnt + CW'(1) == total);
  assign desc_valid = busy;
  assign desc_dlc   = code_q;
  assign desc_crc21 = total > CW'(16);
  assign desc_rrs   = 1'b0;
  assign desc_fdf   = 1'b1;
  assign desc_brs   = brs_q;
  assign desc_esi   = esi_q;
  assign len_err    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      plen   <= '0;
      total  <= '0;
      cnt    <= '0;
      code_q <= '0;
      fill_q <= '0;
      brs_q  <= 1'b0;
      esi_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (len_fire) begin
      busy   <= 1'b1;
      plen   <= req;
      total  <= bytes_of(req_code);
      code_q <= req_code;
      cnt    <= '0;
      fill_q <= fill_in;
      brs_q  <= brs_in;
      esi_q  <= esi_in;
      if (over) err_q <= 1'b1;
    end else if (busy) begin
      if (total == '0) begin
        busy <= 1'b0;
      end else if (out_fire) begin
        if (out_last) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  a_r4_last_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !desc_valid);

  a_r5_crc_width: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_crc21 == (desc_dlc > 4'd10)));

  a_r6_fixed_flags: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (!desc_rrs && desc_fdf));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);

  a_r9_desc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && $past(desc_valid)) |->
      $stable({desc_dlc, desc_crc21, desc_brs, desc_esi}));

  a_r3_no_take_without_out: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_ready && out_valid == in_valid && out_data == in_data));
endmodule

// File: tb/canfd_len_pack_tb.sv
module canfd_len_pack_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       len_valid = 1'b0, len_ready;
  logic [7:0] len_in = '0, fill_in = '0;
  logic       brs_in = 1'b0, esi_in = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid, out_ready = 1'b0, out_last;
  logic [7:0] out_data;
  logic       desc_valid, desc_crc21, desc_rrs, desc_fdf, desc_brs, desc_esi, len_err;
  logic [3:0] desc_dlc;

  int total_n = 0;
  int bad_n = 0;

  always #5 clk = ~clk;

  canfd_len_pack u_dut (
    .clk(clk), .rst_n(rst_n),
    .len_valid(len_valid), .len_ready(len_ready), .len_in(len_in),
    .fill_in(fill_in), .brs_in(brs_in), .esi_in(esi_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .desc_valid(desc_valid), .desc_dlc(desc_dlc), .desc_crc21(desc_crc21),
    .desc_rrs(desc_rrs), .desc_fdf(desc_fdf), .desc_brs(desc_brs), .desc_esi(desc_esi),
    .len_err(len_err)
  );

  // {len[7:0], fill[7:0], brs, esi, dlc[3:0], total[6:0], crc21}
  localparam int NV = 15;
  localparam logic [29:0] VEC [NV] = '{
    {8'd0,  8'h00, 1'b0, 1'b0, 4'd0,  7'd0,  1'b0},
    {8'd1,  8'hCC, 1'b1, 1'b0, 4'd1,  7'd1,  1'b0},
    {8'd5,  8'h55, 1'b0, 1'b1, 4'd5,  7'd5,  1'b0},
    {8'd8,  8'hCC, 1'b1, 1'b1, 4'd8,  7'd8,  1'b0},
    {8'd9,  8'h55, 1'b1, 1'b0, 4'd9,  7'd12, 1'b0},
    {8'd10, 8'h00, 1'b0, 1'b0, 4'd9,  7'd12, 1'b0},
    {8'd12, 8'hCC, 1'b0, 1'b1, 4'd9,  7'd12, 1'b0},
    {8'd13, 8'h55, 1'b1, 1'b0, 4'd10, 7'd16, 1'b0},
    {8'd16, 8'hCC, 1'b0, 1'b0, 4'd10, 7'd16, 1'b0},
    {8'd17, 8'h55, 1'b1, 1'b1, 4'd11, 7'd20, 1'b1},
    {8'd21, 8'hCC, 1'b0, 1'b0, 4'd12, 7'd24, 1'b1},
    {8'd25, 8'h55, 1'b1, 1'b0, 4'd13, 7'd32, 1'b1},
    {8'd33, 8'hCC, 1'b0, 1'b1, 4'd14, 7'd48, 1'b1},
    {8'd49, 8'h55, 1'b1, 1'b0, 4'd15, 7'd64, 1'b1},
    {8'd64, 8'hCC, 1'b0, 1'b0, 4'd15, 7'd64, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] len, input logic [7:0] fill, input bit brs,
                           input bit esi, input logic [3:0] edlc, input int etot,
                           input bit ecrc, input bit stall);
    int pcount;
    logic [7:0] exp_b;
    string cr;
    pcount = (len > 8'd64) ? 64 : int'(len);
    cr = (edlc <= 4'd8) ? "R1" : "R2";
    @(negedge clk);
    len_valid = 1'b1; len_in = len; fill_in = fill; brs_in = brs; esi_in = esi;
    in_valid = 1'b0; out_ready = 1'b0;
    #1 chk(len_ready == 1'b1, "R10 len_ready idle", int'(len_ready), 1);
    @(negedge clk);
    len_valid = 1'b0; fill_in = ~fill; brs_in = ~brs; esi_in = ~esi;
    if (etot == 0) begin
      #1;
      chk(desc_valid == 1'b1, "R9 zero-length desc", int'(desc_valid), 1);
      chk(out_valid == 1'b0, "R9 zero-length no byte", int'(out_valid), 0);
      chk(desc_dlc == 4'd0, "R1 zero code", int'(desc_dlc), 0);
      @(negedge clk); #1;
      chk(desc_valid == 1'b0, "R9 zero-length one cycle", int'(desc_valid), 0);
      return;
    end
    for (int k = 0; k < etot; k++) begin
      if (stall && k == 1) begin
        out_ready = 1'b0;
        in_valid = (k < pcount);
        in_data = 8'h5A ^ k[7:0];
        #1 chk(in_ready == 1'b0, "R3 no take while stalled", int'(in_ready), 0);
        chk(desc_valid == 1'b1, "R9 desc held in stall", int'(desc_valid), 1);
        @(negedge clk);
      end
      out_ready = 1'b1;
      in_valid = (k < pcount);
      in_data = 8'h5A ^ k[7:0];
      exp_b = (k < pcount) ? (8'h5A ^ k[7:0]) : fill;
      #1;
      chk(out_valid == 1'b1, "R3 byte present", int'(out_valid), 1);
      chk(out_data == exp_b, "R3 byte value", int'(out_data), int'(exp_b));
      chk(out_last == (k == etot - 1), "R4 last flag", int'(out_last), int'(k == etot - 1));
      chk(in_ready == (k < pcount), "R8 input take", int'(in_ready), int'(k < pcount));
      chk(desc_valid == 1'b1, "R9 desc valid", int'(desc_valid), 1);
      chk(desc_dlc == edlc, cr, int'(desc_dlc), int'(edlc));
      chk(desc_crc21 == ecrc, "R5 crc select", int'(desc_crc21), int'(ecrc));
      chk(desc_rrs == 1'b0 && desc_fdf == 1'b1, "R6 fixed flags",
          int'({desc_rrs, desc_fdf}), 1);
      chk(desc_brs == brs && desc_esi == esi, "R7 captured flags",
          int'({desc_brs, desc_esi}), int'({brs, esi}));
      @(negedge clk);
    end
    in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk(desc_valid == 1'b0, "R9 desc drops after last", int'(desc_valid), 0);
    chk(out_valid == 1'b0, "R3 no extra byte", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R8 no extra input taken", int'(in_ready), 0);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad_n++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(len_ready == 1'b1, "R10 reset len_ready", int'(len_ready), 1);
    chk(out_valid == 1'b0, "R10 reset out_valid", int'(out_valid), 0);
    chk(desc_valid == 1'b0, "R10 reset desc_valid", int'(desc_valid), 0);
    chk(in_ready == 1'b0, "R10 reset in_ready", int'(in_ready), 0);
    chk(len_err == 1'b0, "R10 reset len_err", int'(len_err), 0);

    for (int i = 0; i < NV; i++) begin
      run_frame(VEC[i][29:22], VEC[i][21:14], VEC[i][13], VEC[i][12],
                VEC[i][11:8], int'(VEC[i][7:1]), VEC[i][0], i[0]);
    end
    chk(len_err == 1'b0, "R8 no error for legal sizes", int'(len_err), 0);

    run_frame(8'd70, 8'h55, 1'b1, 1'b1, 4'd15, 64, 1'b1, 1'b1);
    #1 chk(len_err == 1'b1, "R8 oversize flags error", int'(len_err), 1);
    run_frame(8'd200, 8'hCC, 1'b0, 1'b0, 4'd15, 64, 1'b1, 1'b0);
    run_frame(8'd3, 8'h55, 1'b0, 1'b1, 4'd3, 3, 1'b0, 1'b1);
    #1 chk(len_err == 1'b1, "R8 error sticky", int'(len_err), 1);

    @(negedge clk);
    len_valid = 1'b1; len_in = 8'd2; fill_in = 8'h00;
    @(negedge clk);
    len_in = 8'd9; #1;
    chk(len_ready == 1'b0, "R10 busy refuses size", int'(len_ready), 0);
    len_valid = 1'b0;
    for (int k = 0; k < 2; k++) begin
      in_valid = 1'b1; in_data = 8'hE0 + k[7:0]; out_ready = 1'b1;
      #1 chk(desc_dlc == 4'd2, "R1 first size kept", int'(desc_dlc), 2);
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b0;

    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule